// File: doc/BRIEF.md
# Palettized Framebuffer Line Fetch Engine

This block fetches one frame of pixel data from a 16-bit word-addressed memory and emits it as a raster-order stream of 16-bit pixels. A frame normally begins with a 256-entry palette header. The engine copies that header into an internal palette store first. The depth field in palette entry 0 then sets the bits per pixel and the position where pixel data begins. Pixels of 2, 4 or 8 bits are looked up in the palette. 16-bit pixels are sent out unchanged.

A controller sets up the geometry and the buffer addresses, then pulses `start`. Before any pixel is fetched, the engine checks that the frame fits in the selected buffer. If it does not, it raises a one-cycle sync error and stops. A subpanel word can start output at a given line, or it can cut the frame short. Two frame buffers can be used in turn, and a per-buffer done pulse marks each frame that is accepted.

The output stream uses valid/ready handshaking. `px_valid` stays high and `px_data`, `px_eol` and `px_eof` stay fixed until a cycle in which `px_ready` is high. That cycle transfers exactly one pixel. The sink may hold `px_ready` low for any length of time. The engine then stops fetching until the sink accepts the pixel. All geometry, base, size and mode inputs must stay stable while `busy` is high.

Memory reads have a fixed latency of one cycle. The engine drives `mem_rd` and `mem_addr` in one cycle, and the memory returns the word on `mem_rdata` in the next cycle.

Top module: `plf_line_fetch`

## Requirements
- R1: Unless `pal_mode` is 2, the engine reads the 256 words at word addresses base..base+255 of the current buffer into the palette before any pixel fetch. In mode 2 no palette read occurs, and the palette from the last load stays in use, depth field included.
- R2: Bits 14:12 of palette entry 0 form the depth code. Code 1 selects 2 bpp, code 2 selects 4 bpp, code 3 selects 8 bpp, and codes 4 to 7 select 16 bpp. With code 0 the frame is dropped: no pixel, no sync error, no done pulse and no buffer change.
- R3: Pixel data begins 0x200 bytes after the buffer base when the code is 3 or more, and 0x20 bytes after it when the code is lower. In mode 2 it begins at the base.
- R4: If the data offset plus width*height*bpp/8 bytes is greater than the buffer size plus 2, `sync_err` pulses for one cycle. No pixel is fetched or output, no done pulse is raised, and the buffer does not change.
- R5: A `start` pulse has no effect in three cases: `enable` is low, `pal_mode` is 1, or the engine is busy. While idle the engine issues no memory read and no pixel.
- R6: When subpanel bit 31 is set, bits 25:16 hold a line number. If bit 29 is also set, output begins at that line and runs to the full height. If bit 29 is clear, that number becomes the frame height. An empty line range gives a done pulse and no pixels.
- R7: The line stride is width*bpp/8 bytes (integer division). Line n begins at data offset + n*stride bytes, even when that point falls in the middle of a word.
- R8: Memory bytes are little-endian within each 16-bit word. Sub-byte pixels are taken from bit 0 of each byte upward. Each such pixel indexes the palette, and the output is the 16-bit palette entry.
- R9: At 16 bpp, each memory word is output directly and the palette is not used.
- R10: `buf_done[b]` pulses for one cycle when a frame on buffer b passes the size check. In dual mode the next frame uses the other buffer. In single mode the buffer stays the same.
- R11: While `px_valid` is high and `px_ready` is low, the pixel outputs do not change. `px_eol` marks the last pixel of each line. `px_eof` marks the last pixel of the frame. After reset the stream is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse |
| enable | input | 1 | Engine enable |
| pal_mode | input | 2 | 0/3 load palette, 1 no output, 2 no palette load |
| dual_buf | input | 1 | Alternate between the two buffers |
| fb0_base | input | AW | Word address of buffer 0 |
| fb1_base | input | AW | Word address of buffer 1 |
| fb0_bytes | input | SZW | Size of buffer 0 in bytes |
| fb1_bytes | input | SZW | Size of buffer 1 in bytes |
| width_m1 | input | DW | Pixels per line minus one |
| height_m1 | input | DW | Lines per frame minus one |
| subpanel | input | 32 | Subpanel control word |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| px_valid | output | 1 | Pixel available |
| px_ready | input | 1 | Sink accepts the pixel |
| px_data | output | 16 | Pixel value |
| px_eol | output | 1 | Last pixel of a line |
| px_eof | output | 1 | Last pixel of the frame |
| sync_err | output | 1 | One-cycle size-check failure pulse |
| buf_done | output | 2 | One-cycle per-buffer frame-accepted pulse |
| busy | output | 1 | Frame in progress |

## Verification
The bench focuses on the cases where a design could misplace data:
- A 4 bpp frame three pixels wide has lines that begin in the middle of a word. A design that rounds line starts up to a word boundary would shift every later line.
- The size check is tested at the exact boundary, one byte under and exactly at the limit. An off-by-one in the +2 slack would either let a bad frame through or reject a good one.
- A mode-2 frame follows a frame that loaded depth code 5, and memory word 0 is cleared first. A design that reads the header again would drop the frame. A design that uses the 0x200 offset would output the wrong words.
- Other cases cover both subpanel forms, a dropped code-0 frame, a second `start` while busy, and buffer alternation under random back-pressure. A design that swapped buffers on rejected frames, or that lost or repeated a pixel while stalled, would show mismatched pixels or done counts.

// File: rtl/plf_pkg.sv
package plf_pkg;

  localparam int PAL_IDXW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAL,
    ST_PALW,
    ST_CHECK,
    ST_PIX,
    ST_WAIT,
    ST_OUT
  } plf_state_e;

  // depth code -> bits per pixel; 0 means unsupported
  function automatic logic [4:0] code_to_bpp(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd0;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/plf_palette.sv
module plf_palette #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [15:0]     wdata,
  input  logic [IDXW-1:0] raddr,
  output logic [15:0]     rdata,
  output logic [15:0]     hdr
);
  localparam int N = 1 << IDXW;

  logic [15:0] store [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) store[i] <= '0;
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
  assign hdr   = store[0];
endmodule

// File: rtl/plf_geom.sv
module plf_geom #(
  parameter int DW  = 10,
  parameter int SZW = 24,
  parameter int BW  = 32
) (
  input  logic [2:0]     code,
  input  logic           direct_mode,
  input  logic [DW-1:0]  width_m1,
  input  logic [DW-1:0]  height_m1,
  input  logic [SZW-1:0] frame_bytes,
  input  logic [31:0]    subpanel,
  output logic [4:0]     bpp,
  output logic           skip,
  output logic           too_big,
  output logic [DW:0]    start_line,
  output logic [DW:0]    end_line,
  output logic [BW-1:0]  stride_bits,
  output logic [BW-1:0]  first_bits
);
  import plf_pkg::*;

  logic [DW:0]    w, h, sub_line;
  logic [9:0]     off_bytes;
  logic [39:0]    area_bits, need;
  logic [BW-1:0]  stride_bytes;

  assign bpp       = code_to_bpp(code);
  assign skip      = (code == 3'd0);
  assign w         = (DW+1)'(width_m1) + (DW+1)'(1);
  assign h         = (DW+1)'(height_m1) + (DW+1)'(1);
  assign off_bytes = direct_mode ? 10'd0 : ((code >= 3'd3) ? 10'd512 : 10'd32);

  assign area_bits = 40'(w) * 40'(h) * 40'(bpp);
  assign need      = 40'(off_bytes) + (area_bits >> 3);
  assign too_big   = need > (40'(frame_bytes) + 40'd2);

  assign sub_line   = (DW+1)'(subpanel[25:16]);
  assign start_line = (subpanel[31] && subpanel[29])  ? sub_line : '0;
  assign end_line   = (subpanel[31] && !subpanel[29]) ? sub_line : h;

  assign stride_bytes = BW'((40'(w) * 40'(bpp)) >> 3);
  assign stride_bits  = stride_bytes << 3;
  assign first_bits   = (BW'(off_bytes) + BW'(start_line) * stride_bytes) << 3;
endmodule

// File: rtl/plf_unpack.sv
module plf_unpack (
  input  logic [15:0] word,
  input  logic [3:0]  bit_off,
  input  logic [4:0]  bpp,
  input  logic [15:0] pal_entry,
  output logic [7:0]  pal_idx,
  output logic [15:0] pix
);
  logic [15:0] shifted;

  assign shifted = word >> bit_off;

  always_comb begin
    case (bpp)
      5'd2:    pal_idx = {6'd0, shifted[1:0]};
      5'd4:    pal_idx = {4'd0, shifted[3:0]};
      default: pal_idx = shifted[7:0];
    endcase
  end

  assign pix = (bpp == 5'd16) ? word : pal_entry;
endmodule

// File: rtl/plf_line_fetch.sv
module plf_line_fetch #(
  parameter int AW  = 16,
  parameter int DW  = 10,
  parameter int SZW = 24,
  parameter int BW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           enable,
  input  logic [1:0]     pal_mode,
  input  logic           dual_buf,
  input  logic [AW-1:0]  fb0_base,
  input  logic [AW-1:0]  fb1_base,
  input  logic [SZW-1:0] fb0_bytes,
  input  logic [SZW-1:0] fb1_bytes,
  input  logic [DW-1:0]  width_m1,
  input  logic [DW-1:0]  height_m1,
  input  logic [31:0]    subpanel,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  input  logic [15:0]    mem_rdata,
  output logic           px_valid,
  input  logic           px_ready,
  output logic [15:0]    px_data,
  output logic           px_eol,
  output logic           px_eof,
  output logic           sync_err,
  output logic [1:0]     buf_done,
  output logic           busy
);
  import plf_pkg::*;

  localparam logic [PAL_IDXW-1:0] PAL_LAST = '1;

  plf_state_e          st;
  logic                cur_buf, frm_buf, frm_direct;
  logic [PAL_IDXW-1:0] rd_idx, pend_idx;
  logic                pend_v;
  logic [15:0]         cache_w;
  logic [AW-1:0]       cache_a;
  logic                cache_v;
  logic [BW-1:0]       pbit, lbit;
  logic [DW:0]         px_cnt, line;
  logic [15:0]         out_data;
  logic                out_eol, out_eof, sync_err_q;
  logic [1:0]          done_q;

  logic [AW-1:0]       frm_base, waddr;
  logic [SZW-1:0]      frm_bytes;
  logic [15:0]         pal_hdr, pal_entry, pix;
  logic [PAL_IDXW-1:0] pal_idx;
  logic [4:0]          g_bpp;
  logic                g_skip, g_too_big, hit, last_px, last_line;
  logic [DW:0]         g_start, g_end;
  logic [BW-1:0]       g_stride, g_first;

  assign frm_base  = frm_buf ? fb1_base  : fb0_base;
  assign frm_bytes = frm_buf ? fb1_bytes : fb0_bytes;
  assign waddr     = frm_base + AW'(pbit >> 4);
  assign hit       = cache_v && (cache_a == waddr);
  assign last_px   = (px_cnt == (DW+1)'(width_m1));
  assign last_line = ((line + (DW+1)'(1)) == g_end);

  plf_palette #(.IDXW(PAL_IDXW)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pend_v),
    .waddr (pend_idx),
    .wdata (mem_rdata),
    .raddr (pal_idx),
    .rdata (pal_entry),
    .hdr   (pal_hdr)
  );

  plf_geom #(.DW(DW), .SZW(SZW), .BW(BW)) u_geom (
    .code        (pal_hdr[14:12]),
    .direct_mode (frm_direct),
    .width_m1    (width_m1),
    .height_m1   (height_m1),
    .frame_bytes (frm_bytes),
    .subpanel    (subpanel),
    .bpp         (g_bpp),
    .skip        (g_skip),
    .too_big     (g_too_big),
    .start_line  (g_start),
    .end_line    (g_end),
    .stride_bits (g_stride),
    .first_bits  (g_first)
  );

  plf_unpack u_unpack (
    .word      (cache_w),
    .bit_off   (pbit[3:0]),
    .bpp       (g_bpp),
    .pal_entry (pal_entry),
    .pal_idx   (pal_idx),
    .pix       (pix)
  );

  assign mem_rd   = (st == ST_PAL) || ((st == ST_PIX) && !hit);
  assign mem_addr = (st == ST_PAL) ? frm_base + AW'(rd_idx) : waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_buf    <= 1'b0;
      frm_buf    <= 1'b0;
      frm_direct <= 1'b0;
      rd_idx     <= '0;
      pend_idx   <= '0;
      pend_v     <= 1'b0;
      cache_w    <= '0;
      cache_a    <= '0;
      cache_v    <= 1'b0;
      pbit       <= '0;
      lbit       <= '0;
      px_cnt     <= '0;
      line       <= '0;
      out_data   <= '0;
      out_eol    <= 1'b0;
      out_eof    <= 1'b0;
      sync_err_q <= 1'b0;
      done_q     <= '0;
    end else begin
      sync_err_q <= 1'b0;
      done_q     <= '0;
      pend_v     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start && enable && pal_mode != 2'd1) begin
            frm_buf    <= cur_buf;
            frm_direct <= (pal_mode == 2'd2);
            rd_idx     <= '0;
            st         <= (pal_mode == 2'd2) ? ST_CHECK : ST_PAL;
          end
        end
        ST_PAL: begin
          pend_v   <= 1'b1;
          pend_idx <= rd_idx;
          rd_idx   <= rd_idx + 1'b1;
          if (rd_idx == PAL_LAST) st <= ST_PALW;
        end
        ST_PALW: st <= ST_CHECK;
        ST_CHECK: begin
          if (g_skip) begin
            st <= ST_IDLE;
          end else if (g_too_big) begin
            sync_err_q <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            done_q  <= frm_buf ? 2'b10 : 2'b01;
            if (dual_buf) cur_buf <= ~cur_buf;
            cache_v <= 1'b0;
            line    <= g_start;
            px_cnt  <= '0;
            lbit    <= g_first;
            pbit    <= g_first;
            st      <= (g_start < g_end) ? ST_PIX : ST_IDLE;
          end
        end
        ST_PIX: begin
          if (hit) begin
            out_data <= pix;
            out_eol  <= last_px;
            out_eof  <= last_px && last_line;
            st       <= ST_OUT;
          end else begin
            cache_a <= waddr;
            st      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          cache_w <= mem_rdata;
          cache_v <= 1'b1;
          st      <= ST_PIX;
        end
        ST_OUT: begin
          if (px_ready) begin
            if (last_px) begin
              if (last_line) begin
                st <= ST_IDLE;
              end else begin
                line   <= line + (DW+1)'(1);
                px_cnt <= '0;
                lbit   <= lbit + g_stride;
                pbit   <= lbit + g_stride;
                st     <= ST_PIX;
              end
            end else begin
              px_cnt <= px_cnt + (DW+1)'(1);
              pbit   <= pbit + BW'(g_bpp);
              st     <= ST_PIX;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign px_valid = (st == ST_OUT);
  assign px_data  = out_data;
  assign px_eol   = out_eol;
  assign px_eof   = out_eof;
  assign sync_err = sync_err_q;
  assign buf_done = done_q;
  assign busy     = (st != ST_IDLE);

  // R11: a stalled pixel is held unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_data) && $stable(px_eol) && $stable(px_eof));

  // R11: the frame marker only lands on a line end
  p_eof_eol_r11: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && px_eof |-> px_eol);

  // R10: at most one buffer reports done per cycle
  p_done_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_done));

  // R5: an idle engine makes no memory traffic and no pixels
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !px_valid);

  // R4: a rejected frame gives neither done nor pixels
  p_err_nopix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (buf_done == 2'b00) && !px_valid);

  // R4: nothing is fetched in the cycle after a rejection
  p_err_nofetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !mem_rd);
endmodule

// File: tb/plf_line_fetch_tb.sv
module plf_line_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, enable = 1'b1, dual_buf = 1'b0;
  logic [1:0]  pal_mode = 2'd0;
  logic [15:0] fb0_base = 16'd0, fb1_base = 16'd2048;
  logic [23:0] fb0_bytes = 24'd4000, fb1_bytes = 24'd4000;
  logic [9:0]  width_m1 = 10'd3, height_m1 = 10'd2;
  logic [31:0] subpanel = 32'd0;
  logic        mem_rd, px_valid, px_eol, px_eof, sync_err, busy;
  logic        px_ready = 1'b1;
  logic [15:0] mem_addr, px_data;
  logic [15:0] mem_rdata = 16'd0;
  logic [1:0]  buf_done;

  always #10 clk = ~clk;  // 50 MHz

  plf_line_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .pal_mode(pal_mode),
    .dual_buf(dual_buf), .fb0_base(fb0_base), .fb1_base(fb1_base),
    .fb0_bytes(fb0_bytes), .fb1_bytes(fb1_bytes), .width_m1(width_m1),
    .height_m1(height_m1), .subpanel(subpanel), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
    .px_eol(px_eol), .px_eof(px_eof), .sync_err(sync_err), .buf_done(buf_done), .busy(busy)
  );

  logic [15:0] mem [0:4095];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

  int checks = 0, errors = 0;
  string tag = "R11";
  logic [15:0] q_data[$];
  bit q_eol[$], q_eof[$];
  int n_sync, n_d0, n_d1, n_rd;
  logic [15:0] mdl_pal [0:255];
  int mdl_cur = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // back-pressure source
  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    px_ready <= bp_on ? (lfsr[2] | lfsr[9]) : 1'b1;
  end

  // per-clock comparison against the model queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (sync_err)    n_sync++;
      if (buf_done[0]) n_d0++;
      if (buf_done[1]) n_d1++;
      if (mem_rd)      n_rd++;
      if (px_valid && px_ready) begin
        checks++;
        if (q_data.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected pixel actual %h expected none", tag, px_data);
        end else begin
          logic [15:0] d; bit e, f;
          d = q_data.pop_front(); e = q_eol.pop_front(); f = q_eof.pop_front();
          if (px_data !== d || px_eol !== e || px_eof !== f) begin
            errors++;
            $display("FAIL %s pixel actual %h/%0b/%0b expected %h/%0b/%0b",
                     tag, px_data, px_eol, px_eof, d, e, f);
          end
        end
      end
    end
  end

  function automatic int byte_at(input int base, input int b);
    return (mem[base + b / 2] >> (8 * (b % 2))) & 8'hff;
  endfunction

  task automatic init_buf(input int base, input int code);
    for (int i = 0; i < 2048; i++)
      mem[base + i] = 16'((i * 40503 + base * 7 + 1234) ^ (i >> 3));
    mem[base] = (mem[base] & 16'h8fff) | 16'(code << 12);
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) chk(1'b0, "watchdog", n, 0);
    @(negedge clk);
  endtask

  task automatic run_frame(input int mode, input bit dbl);
    int b, base, size, code, bpp, off, w, h, need, s, e, stride, exp_sync, exp_d0, exp_d1, npx;
    b = mdl_cur; base = b ? 2048 : 0; size = b ? int'(fb1_bytes) : int'(fb0_bytes);
    if (mode != 2) for (int i = 0; i < 256; i++) mdl_pal[i] = mem[base + i];
    code = (mdl_pal[0] >> 12) & 7;
    bpp = (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 8 : 16;
    off = (mode == 2) ? 0 : ((code >= 3) ? 512 : 32);
    w = int'(width_m1) + 1; h = int'(height_m1) + 1;
    need = off + (w * h * bpp) / 8;
    exp_sync = 0; exp_d0 = 0; exp_d1 = 0; npx = 0;
    if (code != 0) begin
      if (need > size + 2) exp_sync = 1;
      else begin
        if (b) exp_d1 = 1; else exp_d0 = 1;
        if (dual_buf) mdl_cur ^= 1;
        s = 0; e = h;
        if (subpanel[31]) begin
          if (subpanel[29]) s = int'(subpanel[25:16]); else e = int'(subpanel[25:16]);
        end
        stride = (w * bpp) / 8;
        for (int l = s; l < e; l++)
          for (int p = 0; p < w; p++) begin
            int lb, v;
            lb = off + l * stride;
            if (bpp == 16) q_data.push_back(16'(byte_at(base, lb + 2*p) | (byte_at(base, lb + 2*p + 1) << 8)));
            else begin
              v = (byte_at(base, lb + (p * bpp) / 8) >> ((p * bpp) % 8)) & ((1 << bpp) - 1);
              q_data.push_back(mdl_pal[v]);
            end
            q_eol.push_back(p == w - 1);
            q_eof.push_back(p == w - 1 && l == e - 1);
            npx++;
          end
      end
    end
    n_sync = 0; n_d0 = 0; n_d1 = 0; n_rd = 0;
    pal_mode = 2'(mode);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (dbl) begin
      repeat (30) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_idle();
    chk(n_sync == exp_sync, "sync_err pulses", n_sync, exp_sync);
    chk(n_d0 == exp_d0 && n_d1 == exp_d1, "done pulses b0*10+b1", n_d0*10 + n_d1, exp_d0*10 + exp_d1);
    chk(q_data.size() == 0, "pixels missing", q_data.size(), 0);
    if (npx == 0) chk(n_rd == ((mode == 2) ? 0 : 256), "memory reads", n_rd, (mode == 2) ? 0 : 256);
    q_data.delete(); q_eol.delete(); q_eof.delete();
  endtask

  task automatic ignored_start();
    n_rd = 0; n_d0 = 0; n_d1 = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "busy after ignored start", busy, 0);
    chk(n_rd == 0 && n_d0 + n_d1 == 0, "reads/done after ignored start", n_rd, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R11";
    chk(px_valid == 0 && busy == 0, "reset idle", px_valid + busy, 0);
    chk(sync_err == 0 && buf_done == 0, "reset pulses", sync_err + buf_done, 0);

    tag = "R1 R2 R3 R8 8bpp"; init_buf(0, 3); width_m1 = 3; height_m1 = 2; run_frame(0, 0);
    tag = "R2 R3 R5 R8 R11 2bpp busy-start"; init_buf(0, 1); width_m1 = 7; height_m1 = 1;
    bp_on = 1; run_frame(3, 1);
    tag = "R7 4bpp odd stride"; init_buf(0, 2); width_m1 = 2; height_m1 = 3; run_frame(0, 0);
    tag = "R9 16bpp direct"; init_buf(0, 5); width_m1 = 2; height_m1 = 1; run_frame(0, 0);
    tag = "R1 R3 mode2 keeps header"; mem[0] = 16'h0000; run_frame(2, 0);
    bp_on = 0;

    tag = "R4 size over"; init_buf(0, 3); width_m1 = 3; height_m1 = 2; fb0_bytes = 24'd521; run_frame(0, 0);
    tag = "R4 size at limit"; fb0_bytes = 24'd522; run_frame(0, 0);
    fb0_bytes = 24'd4000;
    tag = "R2 code 0 skip"; init_buf(0, 0); run_frame(0, 0);

    init_buf(0, 3);
    tag = "R6 subpanel start line"; subpanel = 32'hA001_0000; run_frame(0, 0);
    tag = "R6 subpanel height"; subpanel = 32'h8001_0000; run_frame(0, 0);
    tag = "R6 subpanel empty"; subpanel = 32'h8000_0000; run_frame(0, 0);
    subpanel = 32'd0;

    tag = "R10 dual alternation"; dual_buf = 1; bp_on = 1;
    init_buf(0, 3); init_buf(2048, 2);
    run_frame(0, 0); run_frame(0, 0); run_frame(0, 0);
    dual_buf = 0; bp_on = 0;

    tag = "R5 enable low"; enable = 1'b0; pal_mode = 2'd0; ignored_start(); enable = 1'b1;
    tag = "R5 mode 1"; pal_mode = 2'd1; ignored_start();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule